// File: doc/BRIEF.md
# Dual-Lane Q15 Rounding Multiplier

This block multiplies two packed pairs of signed Q15 halfwords lane by lane. Each 32-bit operand carries an upper lane in bits 31..16 and a lower lane in bits 15..0. Each lane of one operand is multiplied by the lane in the same position of the other operand. Each product is doubled to Q31, rounded half-up to Q15 and truncated. The result is a 64-bit word: the two lane results fill the low 32 bits, and the sign of the upper lane fills the high 32 bits.

The only product that cannot be represented is -1.0 × -1.0. That case is forced to the largest positive Q15 value and sets a sticky overflow flag. The flag holds its value until a reset or a clear strobe. No operand value raises a fault.

A request is a one-cycle pulse on `in_valid` together with both operands. The result and `out_valid` arrive on the next clock, and the flag is updated in the same cycle as the result.

Top module: `q15_pair_mul`

## Requirements
- R1: Outside the saturation case, each lane result equals bits 31..16 of (signed 16×16 product, taken as 32 bits, shifted left by one) + 0x00008000. The upper lane uses operand bits 31..16 and the lower lane uses bits 15..0.
- R2: A lane whose two inputs are both 0x8000 yields 0x7FFF, independently of the other lane.
- R3: The sticky flag `ovf_flag` becomes 1 in the cycle the result of a request with at least one saturating lane appears. It then stays 1 through later requests that do not saturate.
- R4: A pulse on `ovf_clr` makes `ovf_flag` 0 on the next clock, even when a saturating request is accepted in the same cycle. The clear does not change `result`.
- R5: Bits 63..32 of `result` are all copies of bit 31 (the sign of the upper lane result). Bits 31..16 hold the upper lane and bits 15..0 hold the lower lane.
- R6: `out_valid` is 1 exactly one clock after a cycle with `in_valid` high and 0 otherwise. `result` carries that request's value in the same cycle.
- R7: A synchronous active-high `rst` clears `result`, `out_valid` and `ovf_flag` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | First operand, two packed Q15 lanes |
| op_b | input | 32 | Second operand, two packed Q15 lanes |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result valid, one clock after the request |
| result | output | 64 | Sign-extended packed lane results |
| ovf_flag | output | 1 | Sticky saturation flag |

## Verification
Every result, `out_valid` and every flag change is due one clock edge after the input cycle that causes it, because each passes through exactly one register. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge. In the cycle after that, it checks that `out_valid` has dropped again. Flag clears are sampled on the same one-edge schedule, including a clear issued together with a saturating request.

// File: rtl/q15_pair_mul.sv
module q15_pair_mul #(
  parameter int LW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2*LW-1:0] op_a,
  input  logic [2*LW-1:0] op_b,
  input  logic            ovf_clr,
  output logic            out_valid,
  output logic [4*LW-1:0] result,
  output logic            ovf_flag
);
  localparam int PW = 2 * LW;
  localparam logic signed [PW-1:0] PMAX = PW'(1) <<< (PW - 2);
  localparam logic [LW-1:0] QMAX = {1'b0, {(LW-1){1'b1}}};

  logic signed [PW-1:0] prod [2];
  logic        [LW-1:0] lane [2];
  logic        [1:0]    sat;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign prod[i] = PW'(signed'(op_a[i*LW +: LW])) * PW'(signed'(op_b[i*LW +: LW]));
    // only (-1)*(-1) reaches +2^(PW-2)
    assign sat[i]  = (prod[i] == PMAX);
    // bits [PW-1:LW] of (2p + half) == p[PW-2:LW-1] + p[LW-2]
    assign lane[i] = sat[i] ? QMAX : prod[i][PW-2:LW-1] + LW'(prod[i][LW-2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= {{PW{lane[1][LW-1]}}, lane[1], lane[0]};
      if (ovf_clr) ovf_flag <= 1'b0;
      else if (in_valid && |sat) ovf_flag <= 1'b1;
    end
  end
endmodule

module q15_pair_mul_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        ovf_clr,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        ovf_flag
);
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  a_r6_valid_quiet: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  a_r5_sign_fill: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> result[63:32] == {32{result[31]}});
  a_r2_upper_sat: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_a[31:16] == 16'h8000 && op_b[31:16] == 16'h8000 |=> result[31:16] == 16'h7fff);
  a_r2_lower_sat: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_a[15:0] == 16'h8000 && op_b[15:0] == 16'h8000 |=> result[15:0] == 16'h7fff);
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst) ovf_clr |=> !ovf_flag);
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst) ovf_flag && !ovf_clr |=> ovf_flag);
  a_r7_reset: assert property (@(posedge clk) rst |=> !out_valid && !ovf_flag && result == 64'd0);
endmodule

bind q15_pair_mul q15_pair_mul_chk u_chk (.*);

// File: tb/q15_pair_mul_bench.sv
module q15_pair_mul_bench;
  logic clk = 1'b0;
  logic rst, in_valid, ovf_clr;
  logic [31:0] op_a, op_b;
  logic out_valid, ovf_flag;
  logic [63:0] result;
  int checks = 0, bad = 0;

  always #2.5 clk = ~clk;

  q15_pair_mul u_q15_pair_mul (.*);

  function automatic logic [15:0] ref_lane(logic [15:0] a, logic [15:0] b);
    logic signed [31:0] p;
    if (a == 16'h8000 && b == 16'h8000) return 16'h7fff;
    p = 32'(signed'(a)) * 32'(signed'(b));
    p = (p <<< 1) + 32'h0000_8000;
    return p[31:16];
  endfunction

  function automatic logic [63:0] ref_word(logic [31:0] a, logic [31:0] b);
    logic [15:0] hi, lo;
    hi = ref_lane(a[31:16], b[31:16]);
    lo = ref_lane(a[15:0], b[15:0]);
    return {{32{hi[15]}}, hi, lo};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one request; result sampled 1 ns after the edge that registers it
  task automatic run_op(string req, logic [31:0] a, logic [31:0] b, logic clr);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; ovf_clr = clr;
    @(posedge clk); #1;
    check({req, " result"}, result, ref_word(a, b));
    check("R6 valid high", 64'(out_valid), 64'd1);
    @(negedge clk);
    in_valid = 1'b0; ovf_clr = 1'b0;
    @(posedge clk); #1;
    check("R6 valid low", 64'(out_valid), 64'd0);
  endtask

  task automatic pulse_clear();
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; ovf_clr = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 result", result, 64'd0);
    check("R7 valid", 64'(out_valid), 64'd0);
    check("R7 flag", 64'(ovf_flag), 64'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_rounding();
    run_op("R1 half up", 32'h0001_0001, 32'h4000_4000, 1'b0);
    check("R1 half up value", result[31:0], 32'h0001_0001);
    run_op("R1 below half", 32'h0001_ffff, 32'h3fff_4000, 1'b0);
    check("R1 below/neg value", result[31:0], 32'h0000_0000);
    run_op("R1 mixed", 32'h4000_c000, 32'h7fff_4000, 1'b0);
    run_op("R1 max x min", 32'h8000_7fff, 32'h7fff_8000, 1'b0);
    check("R5 negative fill", result[63:32], 32'hffff_ffff);
    check("R3 no sat no flag", 64'(ovf_flag), 64'd0);
  endtask

  task automatic t_sat();
    run_op("R2 upper", 32'h8000_1234, 32'h8000_5678, 1'b0);
    check("R2 upper value", 64'(result[31:16]), 64'h7fff);
    check("R3 flag set", 64'(ovf_flag), 64'd1);
    run_op("R3 plain", 32'h1000_2000, 32'h3000_4000, 1'b0);
    check("R3 sticky", 64'(ovf_flag), 64'd1);
    pulse_clear();
    #1 check("R4 cleared", 64'(ovf_flag), 64'd0);
    check("R4 result kept", result, ref_word(32'h1000_2000, 32'h3000_4000));
    run_op("R2 lower", 32'h0100_8000, 32'hff00_8000, 1'b0);
    check("R2 lower value", 64'(result[15:0]), 64'h7fff);
    check("R3 lower sets", 64'(ovf_flag), 64'd1);
    pulse_clear();
    run_op("R2 both", 32'h8000_8000, 32'h8000_8000, 1'b0);
    check("R5 positive fill", result, 64'h0000_0000_7fff_7fff);
    pulse_clear();
    run_op("R4 clear beats set", 32'h8000_8000, 32'h8000_8000, 1'b1);
    check("R4 clear beats set flag", 64'(ovf_flag), 64'd0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 7 == 0) a[15:0] = 16'h8000;
      run_op("R1 random", a, b, 1'b0);
    end
  endtask

  task automatic t_back_to_back();
    logic [31:0] a0, b0, a1, b1;
    a0 = 32'h1234_8765; b0 = 32'h7abc_0fed; a1 = 32'hfedc_0123; b1 = 32'h8001_7777;
    @(negedge clk); in_valid = 1'b1; op_a = a0; op_b = b0;
    @(negedge clk); op_a = a1; op_b = b1;
    #1 check("R6 first of pair", result, ref_word(a0, b0));
    @(negedge clk); in_valid = 1'b0;
    #1 check("R6 second of pair", result, ref_word(a1, b1));
    check("R6 valid held", 64'(out_valid), 64'd1);
    @(posedge clk); #1;
    check("R6 valid drops", 64'(out_valid), 64'd0);
  endtask

  initial begin
    t_reset();
    t_rounding();
    t_sat();
    t_back_to_back();
    t_random();
    rst = 1'b1;
    @(posedge clk); #1;
    check("R7 late reset flag", 64'(ovf_flag), 64'd0);
    check("R7 late reset valid", 64'(out_valid), 64'd0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(5 * 20000);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule